// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Controller

This block serves a single processor in a multi-source interrupt controller. It tracks two sets of sources: those raised toward this processor and those the processor is currently servicing. It also holds a 4-bit task priority threshold. A routing unit outside the block sends raise requests. The block accepts a request only when the source outranks the threshold. It then drives the processor's interrupt line whenever an accepted source beats everything already raised and everything in service.

The processor talks to the block through a small register port. Reading the acknowledge register drops the interrupt line and hands back the vector of the best raised source. If no source is raised, or the chosen source has gone stale, it returns a spurious vector instead. Writing the end-of-interrupt register retires the best source in service and, when warranted, raises the line again. Per-source priority, vector, activity and sense are inputs owned by the source registers. The block returns one-hot pulses that set or clear a source's activity bit and clear its pending bit.

Top module: `iack_ctrl`

## Requirements
- R1: After reset the task priority reads 15, both sets are empty and `int_o` is low.
- R2: A raise request whose source priority is less than or equal to the task priority has no effect: no `act_set` pulse, no change to `int_o`, and nothing is added to the raised set.
- R3: An accepted raise pulses `act_set` for that source in the same cycle and adds the source to the raised set. It asserts `int_o` at the next edge when its priority is above every in-service priority and at least equal to every raised priority.
- R4: A write to register address 0 (task priority) keeps only data bits [3:0]. A read of address 0 returns that value.
- R5: A read of address 2 (acknowledge) drives `int_o` low at the next edge. It picks the raised source of highest priority, and the lowest index wins a tie. When the source is active and its priority is above the task priority, the read returns its vector ANDed with `VEC_MASK` and moves the source into the in-service set.
- R6: An acknowledge read with the raised set empty returns the spurious vector (all ones ANDed with `VEC_MASK`).
- R7: When the picked source is inactive, or its priority no longer exceeds the task priority, the acknowledge read returns the spurious vector and pulses `act_clr` for it. In every case the picked source leaves the raised set.
- R8: Acknowledging an edge source (`src_level` bit 0) pulses both `act_clr` and `pend_clr` for it. Acknowledging a level source (`src_level` bit 1) that is valid pulses neither.
- R9: A write to address 3 (end-of-interrupt) removes the highest-priority in-service source, with ties going to the lowest index. `int_o` is then high only if a raised source exists and either nothing remains in service or the best raised priority exceeds the best remaining in-service priority.
- R10: A read of address 3 returns 0. A read of address 1 (identity) returns `CPU_ID`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_valid | input | 1 | Raise request from the routing unit |
| raise_src | input | IW | Index of the source being raised |
| src_prio | input | NUM_SRC*4 | Per-source priority, 4 bits each |
| src_vec | input | NUM_SRC*VEC_W | Per-source vector |
| src_active | input | NUM_SRC | Per-source activity bit |
| src_level | input | NUM_SRC | Per-source sense, 1 = level |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 task priority, 1 identity, 2 acknowledge, 3 end-of-interrupt |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | High the cycle after a read |
| int_o | output | 1 | Interrupt line to the processor |
| act_set | output | NUM_SRC | One-hot pulse: set source activity |
| act_clr | output | NUM_SRC | One-hot pulse: clear source activity |
| pend_clr | output | NUM_SRC | One-hot pulse: clear source pending |

## Verification
The activity and pending pulses are combinational, so they appear in the same cycle as the raise or acknowledge that causes them. `int_o`, the two sets, the task priority and `reg_rdata` all change at the first rising edge after the request. The bench drives each request on a falling edge and captures the pulses 1 ns later. It then steps to the next falling edge and reads the registered results there, so every check lands exactly one edge after its stimulus. The sweeps cover all 256 pairings of task priority and source priority, and all 225 pairings of two nonzero source priorities.

// File: rtl/iack_pkg.sv
package iack_pkg;
  localparam int PRIO_W = 4;

  typedef enum logic [1:0] {
    RA_TASKPRI = 2'd0,
    RA_WHOAMI  = 2'd1,
    RA_ACK     = 2'd2,
    RA_EOI     = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/iack_pick.sv
module iack_pick #(
  parameter int N  = 16,
  parameter int PW = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  output logic            found,
  output logic [IW-1:0]   idx,
  output logic [PW-1:0]   best
);
  // Strictly greater comparison keeps the lowest index on ties.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || (prio[i*PW +: PW] > best))) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/iack_core.sv
module iack_core #(
  parameter int          NUM_SRC  = 16,
  parameter int          VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_MASK = '1,
  parameter int          IW       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     raise_valid,
  input  logic [IW-1:0]            raise_src,
  input  logic                     ack_rd,
  input  logic                     eoi_wr,
  input  logic                     tpr_wr,
  input  logic [iack_pkg::PRIO_W-1:0] tpr_wdata,
  input  logic [NUM_SRC*iack_pkg::PRIO_W-1:0] src_prio,
  input  logic [NUM_SRC*VEC_W-1:0] src_vec,
  input  logic [NUM_SRC-1:0]       src_active,
  input  logic [NUM_SRC-1:0]       src_level,
  output logic                     int_o,
  output logic [iack_pkg::PRIO_W-1:0] tpr_o,
  output logic [VEC_W-1:0]         ack_vec,
  output logic [NUM_SRC-1:0]       act_set,
  output logic [NUM_SRC-1:0]       act_clr,
  output logic [NUM_SRC-1:0]       pend_clr
);
  import iack_pkg::*;

  localparam int PW = PRIO_W;
  localparam logic [NUM_SRC-1:0] ONE_HOT0 = NUM_SRC'(1);
  localparam logic [VEC_W-1:0]   SPUR_VEC = VEC_MASK;
  localparam logic [PW-1:0]      TPR_RST  = '1;

  logic [NUM_SRC-1:0] raised_q, raised_d;
  logic [NUM_SRC-1:0] insvc_q, insvc_d;
  logic [PW-1:0]      tpr_q, tpr_d;
  logic               int_q, int_d;

  // best raised source
  logic          r_found;
  logic [IW-1:0] r_idx;
  logic [PW-1:0] r_best;
  // best in-service source
  logic          s_found;
  logic [IW-1:0] s_idx;
  logic [PW-1:0] s_best;
  // best in-service source left after retiring s_idx
  logic          l_found;
  logic [IW-1:0] l_idx;
  logic [PW-1:0] l_best;

  logic [NUM_SRC-1:0] r_oh, s_oh, insvc_left, rs_oh;
  logic [PW-1:0]      rs_prio;
  logic               raise_ok, raise_fire;
  logic               ack_good, eoi_fire;
  logic               sel_level, sel_active;

  iack_pick #(.N(NUM_SRC), .PW(PW), .IW(IW)) u_pick_raised (
    .req(raised_q), .prio(src_prio), .found(r_found), .idx(r_idx), .best(r_best)
  );

  iack_pick #(.N(NUM_SRC), .PW(PW), .IW(IW)) u_pick_insvc (
    .req(insvc_q), .prio(src_prio), .found(s_found), .idx(s_idx), .best(s_best)
  );

  iack_pick #(.N(NUM_SRC), .PW(PW), .IW(IW)) u_pick_left (
    .req(insvc_left), .prio(src_prio), .found(l_found), .idx(l_idx), .best(l_best)
  );

  // ---------------- decode of the raise path ----------------
  always_comb begin
    rs_prio    = src_prio[int'(raise_src)*PW +: PW];
    raise_ok   = raise_valid && (rs_prio > tpr_q);
    rs_oh      = raise_ok ? (ONE_HOT0 << raise_src) : '0;
    raise_fire = raise_ok
                 && (!s_found || (rs_prio > s_best))
                 && (!r_found || (rs_prio >= r_best));
  end

  // ---------------- decode of acknowledge / end-of-interrupt ----------------
  always_comb begin
    r_oh       = r_found ? (ONE_HOT0 << r_idx) : '0;
    s_oh       = s_found ? (ONE_HOT0 << s_idx) : '0;
    insvc_left = insvc_q & ~s_oh;
    sel_active = src_active[r_idx];
    sel_level  = src_level[r_idx];
    ack_good   = r_found && sel_active && (r_best > tpr_q);
    ack_vec    = ack_good ? (src_vec[int'(r_idx)*VEC_W +: VEC_W] & VEC_MASK)
                          : SPUR_VEC;
    eoi_fire   = r_found && (!l_found || (r_best > l_best));
  end

  // ---------------- source attribute pulses ----------------
  always_comb begin
    act_set  = rs_oh;
    act_clr  = '0;
    pend_clr = '0;
    if (ack_rd && r_found) begin
      if (!ack_good || !sel_level) act_clr  = r_oh;
      if (!sel_level)              pend_clr = r_oh;
    end
  end

  // ---------------- next state ----------------
  always_comb begin
    raised_d = raised_q;
    insvc_d  = insvc_q;
    int_d    = int_q;
    tpr_d    = tpr_q;

    if (ack_rd)             raised_d = raised_d & ~r_oh;
    raised_d = raised_d | rs_oh;

    if (eoi_wr)             insvc_d = insvc_d & ~s_oh;
    if (ack_rd && ack_good) insvc_d = insvc_d | r_oh;

    if (raise_fire)         int_d = 1'b1;
    if (eoi_wr)             int_d = eoi_fire || raise_fire;
    if (ack_rd)             int_d = 1'b0;

    if (tpr_wr)             tpr_d = tpr_wdata;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      raised_q <= '0;
      insvc_q  <= '0;
      int_q    <= 1'b0;
    end else begin
      raised_q <= raised_d;
      insvc_q  <= insvc_d;
      int_q    <= int_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tpr_q <= TPR_RST;
    end else if (tpr_wr) begin
      tpr_q <= tpr_d;
    end
  end

  assign int_o = int_q;
  assign tpr_o = tpr_q;

  // ---------------- assertions ----------------
  // R5
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ack_rd |=> !int_o);

  // R2
  low_raise_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (raise_valid && !ack_rd && !eoi_wr && (rs_prio <= tpr_q))
      |=> ($stable(raised_q) && $stable(int_q)));

  // R4
  tpr_keep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    tpr_wr |=> (tpr_q == $past(tpr_wdata)));

  // R9
  eoi_retire_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (eoi_wr && s_found && !ack_rd) |=> !insvc_q[$past(s_idx)]);

  // R9
  left_pick_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    l_found |-> (insvc_q[l_idx] && (l_idx != s_idx) && (l_best <= s_best)));

  // R8
  pend_sub_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((pend_clr & ~act_clr) == '0) && $onehot0(act_clr));

  // R7
  ack_leave_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_rd && r_found && !raise_valid) |=> !raised_q[$past(r_idx)]);
endmodule

// File: rtl/iack_ctrl.sv
module iack_ctrl #(
  parameter int               NUM_SRC  = 16,
  parameter int               VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_MASK = '1,
  parameter int               CPU_ID   = 0,
  parameter int               IW       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     raise_valid,
  input  logic [IW-1:0]            raise_src,
  input  logic [NUM_SRC*4-1:0]     src_prio,
  input  logic [NUM_SRC*VEC_W-1:0] src_vec,
  input  logic [NUM_SRC-1:0]       src_active,
  input  logic [NUM_SRC-1:0]       src_level,
  input  logic                     reg_rd,
  input  logic                     reg_wr,
  input  logic [1:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic                     reg_rvalid,
  output logic                     int_o,
  output logic [NUM_SRC-1:0]       act_set,
  output logic [NUM_SRC-1:0]       act_clr,
  output logic [NUM_SRC-1:0]       pend_clr
);
  import iack_pkg::*;

  localparam logic [31:0] ID_WORD = 32'(CPU_ID);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  reg_addr_e addr;
  logic ack_rd, eoi_wr, tpr_wr;
  logic [PRIO_W-1:0] tpr;
  logic [VEC_W-1:0]  ack_vec;
  logic [31:0]       rdata_q, rdata_d;
  logic              rvalid_q;
  logic              unused_wdata;

  assign addr         = reg_addr_e'(reg_addr);
  assign ack_rd       = reg_rd && (addr == RA_ACK);
  assign eoi_wr       = reg_wr && (addr == RA_EOI);
  assign tpr_wr       = reg_wr && (addr == RA_TASKPRI);
  assign unused_wdata = ^reg_wdata[31:PRIO_W];

  iack_core #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_MASK(VEC_MASK), .IW(IW)
  ) u_core (
    .clk        (clk),
    .rst_ni     (rst_core_n),
    .raise_valid(raise_valid),
    .raise_src  (raise_src),
    .ack_rd     (ack_rd),
    .eoi_wr     (eoi_wr),
    .tpr_wr     (tpr_wr),
    .tpr_wdata  (reg_wdata[PRIO_W-1:0]),
    .src_prio   (src_prio),
    .src_vec    (src_vec),
    .src_active (src_active),
    .src_level  (src_level),
    .int_o      (int_o),
    .tpr_o      (tpr),
    .ack_vec    (ack_vec),
    .act_set    (act_set),
    .act_clr    (act_clr),
    .pend_clr   (pend_clr)
  );

  always_comb begin
    unique case (addr)
      RA_TASKPRI: rdata_d = 32'(tpr);
      RA_WHOAMI:  rdata_d = ID_WORD;
      RA_ACK:     rdata_d = 32'(ack_vec);
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      if (reg_rd) rdata_q <= rdata_d;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;

  // R10
  eoi_zero_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (reg_rd && (addr == RA_EOI)) |=> (reg_rvalid && (reg_rdata == '0)));

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_core_n |=> !int_o);
endmodule

// File: tb/iack_ctrl_tb.sv
`timescale 1ns/1ps
module iack_ctrl_tb;
  localparam int NS = 4;
  localparam int VW = 8;
  localparam logic [VW-1:0] MASK = 8'h7F;
  localparam logic [31:0] SPUR = 32'h7F;

  logic clk = 1'b0;
  logic rst_n;
  logic raise_valid;
  logic [1:0] raise_src;
  logic [NS*4-1:0] src_prio;
  logic [NS*VW-1:0] src_vec;
  logic [NS-1:0] src_active, src_level;
  logic reg_rd, reg_wr;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic reg_rvalid, int_o;
  logic [NS-1:0] act_set, act_clr, pend_clr;
  logic [NS-1:0] cap_set, cap_clr, cap_pclr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  iack_ctrl #(.NUM_SRC(NS), .VEC_W(VW), .VEC_MASK(MASK), .CPU_ID(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .raise_valid(raise_valid), .raise_src(raise_src),
    .src_prio(src_prio), .src_vec(src_vec), .src_active(src_active),
    .src_level(src_level), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .int_o(int_o), .act_set(act_set), .act_clr(act_clr), .pend_clr(pend_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic op(input bit rd, input bit wr, input logic [1:0] a, input logic [31:0] d);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
    #1;
    cap_set = act_set; cap_clr = act_clr; cap_pclr = pend_clr;
    @(negedge clk);
    reg_rd = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic raise(input int s);
    raise_valid = 1'b1; raise_src = 2'(s);
    #1;
    cap_set = act_set; cap_clr = act_clr; cap_pclr = pend_clr;
    @(negedge clk);
    raise_valid = 1'b0;
  endtask

  task automatic set_prio(input int s, input int p);
    src_prio[s*4 +: 4] = 4'(p);
  endtask

  function automatic logic [31:0] vec_of(input int s);
    return 32'(src_vec[s*VW +: VW] & MASK);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; raise_valid = 1'b0; raise_src = '0;
    reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    src_prio = '0; src_active = '0; src_level = '0;
    for (int i = 0; i < NS; i++) src_vec[i*VW +: VW] = 8'(8'h20 + i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 int_o", 32'(int_o), 0);
    op(1, 0, 2'd0, 0);
    chk("R1 taskpri", reg_rdata, 32'd15);
    // R6 empty raised set
    op(1, 0, 2'd2, 0);
    chk("R6 spurious", reg_rdata, SPUR);
    // R10 reads
    op(1, 0, 2'd3, 0);
    chk("R10 eoi read", reg_rdata, 0);
    op(1, 0, 2'd1, 0);
    chk("R10 whoami", reg_rdata, 32'd3);
    // R4 only low bits kept
    op(0, 1, 2'd0, 32'hFFFF_FFF6);
    op(1, 0, 2'd0, 0);
    chk("R4 taskpri", reg_rdata, 32'd6);

    // R2/R3/R5: sweep task priority against source priority
    for (int t = 0; t < 16; t++) begin
      for (int p = 0; p < 16; p++) begin
        bit acc;
        acc = (p > t);
        op(0, 1, 2'd0, 32'(t));
        set_prio(0, p); src_active[0] = 1'b0; src_level[0] = 1'b0;
        raise(0);
        chk(acc ? "R3 act_set" : "R2 act_set", 32'(cap_set), acc ? 32'd1 : 32'd0);
        chk(acc ? "R3 int_o" : "R2 int_o", 32'(int_o), 32'(acc));
        if (acc) src_active[0] = 1'b1;
        op(1, 0, 2'd2, 0);
        chk(acc ? "R5 vector" : "R6 spurious", reg_rdata, acc ? vec_of(0) : SPUR);
        chk("R5 int drop", 32'(int_o), 0);
        chk("R8 edge act_clr", 32'(cap_clr), acc ? 32'd1 : 32'd0);
        src_active[0] = 1'b0;
        if (acc) op(0, 1, 2'd3, 0);
      end
    end

    // pair sweep on sources 1 and 2
    op(0, 1, 2'd0, 0);
    for (int pa = 1; pa < 16; pa++) begin
      for (int pb = 1; pb < 16; pb++) begin
        int w, o;
        set_prio(1, pa); set_prio(2, pb);
        src_level[1] = 1'b0; src_level[2] = 1'b0;
        raise(1); src_active[1] = 1'b1;
        chk("R3 int first", 32'(int_o), 1);
        op(1, 0, 2'd2, 0); src_active[1] = 1'b0;
        chk("R5 vec a", reg_rdata, vec_of(1));
        raise(2); src_active[2] = 1'b1;
        chk("R3 int vs in-service", 32'(int_o), 32'(pb > pa));
        op(0, 1, 2'd3, 0);
        chk("R9 reraise empty insvc", 32'(int_o), 1);
        op(1, 0, 2'd2, 0); src_active[2] = 1'b0;
        chk("R5 vec b", reg_rdata, vec_of(2));
        op(0, 1, 2'd3, 0);
        chk("R9 int after eoi", 32'(int_o), 0);
        // both raised: order by priority, tie to lower index
        raise(1); src_active[1] = 1'b1;
        raise(2); src_active[2] = 1'b1;
        w = (pb > pa) ? 2 : 1; o = 3 - w;
        op(1, 0, 2'd2, 0);
        chk("R5 winner", reg_rdata, vec_of(w));
        op(1, 0, 2'd2, 0);
        chk("R5 second", reg_rdata, vec_of(o));
        op(1, 0, 2'd2, 0);
        chk("R6 drained", reg_rdata, SPUR);
        src_active[1] = 1'b0; src_active[2] = 1'b0;
        op(0, 1, 2'd3, 0);
        op(0, 1, 2'd3, 0);
        chk("R9 int idle", 32'(int_o), 0);
      end
    end

    // R7 stale by activity (level source dropped)
    set_prio(1, 5); src_level[1] = 1'b1;
    raise(1); src_active[1] = 1'b1;
    src_active[1] = 1'b0;
    op(1, 0, 2'd2, 0);
    chk("R7 inactive spurious", reg_rdata, SPUR);
    chk("R7 act_clr", 32'(cap_clr), 32'b0010);
    chk("R8 level no pend_clr", 32'(cap_pclr), 0);
    op(1, 0, 2'd2, 0);
    chk("R7 removed", reg_rdata, SPUR);

    // R7 stale by task priority
    raise(1); src_active[1] = 1'b1;
    op(0, 1, 2'd0, 32'd5);
    op(1, 0, 2'd2, 0);
    chk("R7 tpr spurious", reg_rdata, SPUR);
    chk("R7 tpr act_clr", 32'(cap_clr), 32'b0010);
    op(0, 1, 2'd0, 0);

    // R8 valid level acknowledge leaves activity and pending alone
    op(1, 0, 2'd2, 0);
    raise(1);
    op(1, 0, 2'd2, 0);
    chk("R8 level vec", reg_rdata, vec_of(1));
    chk("R8 level act_clr", 32'(cap_clr), 0);
    chk("R8 level pend_clr", 32'(cap_pclr), 0);
    src_active[1] = 1'b0;
    op(0, 1, 2'd3, 0);

    // R5 vector masking; R8 edge pend_clr
    src_vec[3*VW +: VW] = 8'hA3; set_prio(3, 3); src_level[3] = 1'b0;
    raise(3); src_active[3] = 1'b1;
    op(1, 0, 2'd2, 0);
    chk("R5 masked vec", reg_rdata, 32'h23);
    chk("R8 edge pend_clr", 32'(cap_pclr), 32'b1000);
    src_active[3] = 1'b0;
    op(0, 1, 2'd3, 0);

    // R9 with a source left in service
    set_prio(1, 5); set_prio(2, 9); set_prio(3, 7);
    src_level[1] = 1'b0; src_level[2] = 1'b0;
    raise(1); src_active[1] = 1'b1;
    op(1, 0, 2'd2, 0); src_active[1] = 1'b0;
    raise(2); src_active[2] = 1'b1;
    chk("R3 outranks insvc", 32'(int_o), 1);
    op(1, 0, 2'd2, 0); src_active[2] = 1'b0;
    chk("R5 vec 2", reg_rdata, 32'h22);
    raise(3); src_active[3] = 1'b1;
    chk("R3 below insvc", 32'(int_o), 0);
    op(0, 1, 2'd3, 0);
    chk("R9 retire highest", 32'(int_o), 1);
    op(1, 0, 2'd2, 0); src_active[3] = 1'b0;
    chk("R5 vec 3", reg_rdata, 32'h23);
    op(0, 1, 2'd3, 0);
    chk("R9 eoi no raised", 32'(int_o), 0);
    op(0, 1, 2'd3, 0);
    op(1, 0, 2'd2, 0);
    chk("R6 end empty", reg_rdata, SPUR);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule